// File: doc/BRIEF.md
# Load/Store Address Generation and Writeback Unit

This unit sits between instruction decode and the data memory port of a load/store pipeline. For each request it decodes a five-bit addressing-mode field and picks the offset. It adds the offset to the base register value or subtracts it. From the mode it decides whether memory sees the original base (post-indexed) or the adjusted value (pre-indexed), and whether the adjusted value is written back into the base register.

The same request also carries the raw memory read data and the store source value. The unit produces the sized and extended load result, the size-masked store data and the access size. All results are registered: they appear one cycle after a request is accepted and hold until the next request.

Two transfer classes are handled. The word/byte class always takes the precomputed offset operand, and bit 2 of the mode selects a byte access. The halfword/signed class uses bit 2 to choose between the register offset and an 8-bit immediate that arrives as two 4-bit halves; a separate kind input selects unsigned halfword, signed byte or signed halfword. A load whose destination register is the base register, with writeback enabled, gives priority to the loaded data. The base writeback is then dropped and a hazard flag is raised.

Top module: `lsagu_top`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. All other outputs change only in the cycle after an accepted request and hold their values otherwise.
- R2: The mode field is ordered bit 4 pre-index, bit 3 up, bit 2 byte/immediate select, bit 1 writeback, bit 0 load. Up=1 adds the offset to `base` and up=0 subtracts it, for register and immediate offsets alike, modulo 2^DW.
- R3: With pre-index=0, `ea` equals `base`, `wb_val` equals base±offset, and `wb_en` is 1 whatever the writeback bit holds (unless R10 applies).
- R4: With pre-index=1 and writeback=0, `ea` equals base±offset and `wb_en` is 0.
- R5: With pre-index=1 and writeback=1, `ea` equals base±offset, `wb_val` equals `ea`, and `wb_en` is 1 (unless R10 applies).
- R6: In the halfword/signed class (`cls`=1), mode bit 2 = 1 selects the offset {`imm_hi`,`imm_lo`} zero-extended, and bit 2 = 0 selects `off_reg`. In the word/byte class (`cls`=0) the offset is always `off_reg`.
- R7: In the word/byte class, mode bit 2 = 1 gives `size`=2'b00 (byte), `ld_data` = `rdata[7:0]` zero-extended and `st_data` = `st_src[7:0]` zero-extended. Bit 2 = 0 gives `size`=2'b10 (word) with `ld_data`=`rdata` and `st_data`=`st_src`.
- R8: In the halfword/signed class, `hs_kind` 2'b10 makes `ld_data` `rdata[7:0]` sign-extended from bit 7. 2'b11 sign-extends `rdata[15:0]` from bit 15, and 2'b00/2'b01 zero-extend `rdata[15:0]`. `st_data` is `st_src[15:0]` zero-extended. `size` is 2'b00 for a load with kind 2'b10 and 2'b01 otherwise.
- R9: `is_load` equals mode bit 0 of the accepted request.
- R10: When mode bit 0 = 1, writeback would be enabled, and `rd_idx` equals `rn_idx`, then `hazard` is 1 and `wb_en` is 0. In every other case `hazard` is 0.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request accepted this cycle |
| mode | input | 5 | Addressing-mode field {pre, up, bsel, wback, load} |
| cls | input | 1 | 0 word/byte class, 1 halfword/signed class |
| hs_kind | input | 2 | Halfword-class kind: 10 signed byte, 11 signed half, else unsigned half |
| base | input | DW | Base register value |
| off_reg | input | DW | Register (or precomputed) offset operand |
| imm_hi | input | 4 | Upper half of split immediate |
| imm_lo | input | 4 | Lower half of split immediate |
| rd_idx | input | RW | Destination/source register index |
| rn_idx | input | RW | Base register index |
| st_src | input | DW | Store source value |
| rdata | input | DW | Raw memory read data |
| out_valid | output | 1 | Results valid |
| ea | output | DW | Effective address |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | DW | Base writeback value |
| is_load | output | 1 | Access direction, 1 = load |
| size | output | 2 | 00 byte, 01 half, 10 word |
| ld_data | output | DW | Extended load result |
| st_data | output | DW | Masked store data |
| hazard | output | 1 | Load destination equals written-back base |

## Verification
The bench builds the unit at the default 32-bit width. At that width the wrap of a subtraction below zero and of an addition past 2^32 can both be reached with small operands, and the sign bits at 7 and 15 sit well below the top bit, so extension is visible across the whole word. It uses the invert-plus-carry adder variant with 4-bit register indices. Random indices then collide about one request in sixteen, on top of the directed destination-equals-base loads. All 32 mode values are swept in both classes with up=0 and up=1 operands.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } xfer_size_e;

   typedef struct packed {
      logic pre;
      logic up;
      logic bsel;
      logic wback;
      logic load;
   } amode_t;

   localparam logic [1:0] HK_SBYTE = 2'b10;
   localparam logic [1:0] HK_SHALF = 2'b11;

endpackage

// File: rtl/lsagu_offset.sv
module lsagu_offset #(
   parameter int DW    = 32,
   parameter int IMM_W = 4
) (
   input  logic             cls,
   input  logic             imm_sel,
   input  logic [DW-1:0]    off_reg,
   input  logic [IMM_W-1:0] imm_hi,
   input  logic [IMM_W-1:0] imm_lo,
   output logic [DW-1:0]    off
);
   localparam int PAD = DW - 2*IMM_W;

   logic [DW-1:0] imm_ext;
   assign imm_ext = {{PAD{1'b0}}, imm_hi, imm_lo};

   always_comb begin
      if (cls && imm_sel) off = imm_ext;
      else                off = off_reg;
   end
endmodule

// File: rtl/lsagu_addr.sv
module lsagu_addr #(
   parameter int DW          = 32,
   parameter int ADDER_STYLE = 1
) (
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] off,
   input  logic          up,
   output logic [DW-1:0] sum
);
   generate
      if (ADDER_STYLE == 0) begin : g_dual
         logic [DW-1:0] s_add, s_sub;
         assign s_add = base + off;
         assign s_sub = base - off;
         assign sum   = up ? s_add : s_sub;
      end else begin : g_inv
         logic [DW-1:0] opnd;
         logic [DW-1:0] cin;
         assign opnd = off ^ {DW{~up}};
         assign cin  = {{(DW-1){1'b0}}, ~up};
         assign sum  = base + opnd + cin;
      end
   endgenerate
endmodule

// File: rtl/lsagu_extend.sv
module lsagu_extend
   import lsagu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          cls,
   input  logic          bsel,
   input  logic          load,
   input  logic [1:0]    hs_kind,
   input  logic [DW-1:0] rdata,
   input  logic [DW-1:0] st_src,
   output xfer_size_e    size,
   output logic [DW-1:0] ld_data,
   output logic [DW-1:0] st_data
);
   logic [DW-1:0] zb_ld, zh_ld, sb_ld, sh_ld, zb_st, zh_st;

   assign zb_ld = {{(DW-8){1'b0}},  rdata[7:0]};
   assign zh_ld = {{(DW-16){1'b0}}, rdata[15:0]};
   assign sb_ld = {{(DW-8){rdata[7]}},   rdata[7:0]};
   assign sh_ld = {{(DW-16){rdata[15]}}, rdata[15:0]};
   assign zb_st = {{(DW-8){1'b0}},  st_src[7:0]};
   assign zh_st = {{(DW-16){1'b0}}, st_src[15:0]};

   always_comb begin
      if (!cls) begin
         size    = bsel ? SZ_BYTE : SZ_WORD;
         ld_data = bsel ? zb_ld : rdata;
         st_data = bsel ? zb_st : st_src;
      end else begin
         st_data = zh_st;
         size    = (load && hs_kind == HK_SBYTE) ? SZ_BYTE : SZ_HALF;
         case (hs_kind)
            HK_SBYTE: ld_data = sb_ld;
            HK_SHALF: ld_data = sh_ld;
            default:  ld_data = zh_ld;
         endcase
      end
   end
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
   import lsagu_pkg::*;
#(
   parameter int DW          = 32,
   parameter int RW          = 4,
   parameter int ADDER_STYLE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [4:0]    mode,
   input  logic          cls,
   input  logic [1:0]    hs_kind,
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] off_reg,
   input  logic [3:0]    imm_hi,
   input  logic [3:0]    imm_lo,
   input  logic [RW-1:0] rd_idx,
   input  logic [RW-1:0] rn_idx,
   input  logic [DW-1:0] st_src,
   input  logic [DW-1:0] rdata,
   output logic          out_valid,
   output logic [DW-1:0] ea,
   output logic          wb_en,
   output logic [DW-1:0] wb_val,
   output logic          is_load,
   output logic [1:0]    size,
   output logic [DW-1:0] ld_data,
   output logic [DW-1:0] st_data,
   output logic          hazard
);
   generate
      if (DW < 16 || DW > 64) begin : g_bad_dw
         $error("lsagu_top: DW must lie in 16..64");
      end
      if (RW < 1 || RW > 8) begin : g_bad_rw
         $error("lsagu_top: RW must lie in 1..8");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("lsagu_top: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   amode_t        m;
   logic [DW-1:0] off_n, sum_n, ea_n, ld_n, st_n;
   xfer_size_e    size_n;
   logic          wb_raw, haz_n;

   assign m = amode_t'(mode);

   lsagu_offset #(.DW(DW), .IMM_W(4)) u_off (
      .cls(cls), .imm_sel(m.bsel), .off_reg(off_reg),
      .imm_hi(imm_hi), .imm_lo(imm_lo), .off(off_n)
   );

   lsagu_addr #(.DW(DW), .ADDER_STYLE(ADDER_STYLE)) u_addr (
      .base(base), .off(off_n), .up(m.up), .sum(sum_n)
   );

   lsagu_extend #(.DW(DW)) u_ext (
      .cls(cls), .bsel(m.bsel), .load(m.load), .hs_kind(hs_kind),
      .rdata(rdata), .st_src(st_src),
      .size(size_n), .ld_data(ld_n), .st_data(st_n)
   );

   assign ea_n   = m.pre ? sum_n : base;
   assign wb_raw = ~m.pre | m.wback;
   assign haz_n  = m.load & wb_raw & (rd_idx == rn_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ea        <= '0;
         wb_en     <= 1'b0;
         wb_val    <= '0;
         is_load   <= 1'b0;
         size      <= 2'b00;
         ld_data   <= '0;
         st_data   <= '0;
         hazard    <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            ea      <= ea_n;
            wb_en   <= wb_raw & ~haz_n;
            wb_val  <= sum_n;
            is_load <= m.load;
            size    <= size_n;
            ld_data <= ld_n;
            st_data <= st_n;
            hazard  <= haz_n;
         end
      end
   end
endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
   parameter int DW = 32,
   parameter int RW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [4:0]    mode,
   input logic          cls,
   input logic [DW-1:0] base,
   input logic [RW-1:0] rd_idx,
   input logic [RW-1:0] rn_idx,
   input logic          out_valid,
   input logic [DW-1:0] ea,
   input logic          wb_en,
   input logic [DW-1:0] wb_val,
   input logic          is_load,
   input logic [DW-1:0] ld_data,
   input logic          hazard
);
   logic collide;
   assign collide = mode[0] && (rd_idx == rn_idx) && (!mode[4] || mode[1]);

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> out_valid == $past(req_valid));

   assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(ea) && $stable(wb_val));

   assert_post_uses_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !mode[4] |=> ea == $past(base));

   assert_post_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !mode[4] && !collide |=> wb_en);

   assert_pre_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode[4] && !mode[1] |=> !wb_en && !hazard);

   assert_pre_wb_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && mode[4] && mode[1] |=> wb_val == ea);

   assert_byte_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !cls && mode[2] |=> ld_data[DW-1:8] == '0);

   assert_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> is_load == $past(mode[0]));

   assert_hazard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> hazard == $past(collide) && !(hazard && wb_en));
endmodule

bind lsagu_top lsagu_chk #(.DW(DW), .RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .cls(cls),
   .base(base), .rd_idx(rd_idx), .rn_idx(rn_idx), .out_valid(out_valid),
   .ea(ea), .wb_en(wb_en), .wb_val(wb_val), .is_load(is_load),
   .ld_data(ld_data), .hazard(hazard)
);

// File: tb/sim_lsagu_top.sv
`timescale 1ns/1ps
module sim_lsagu_top;
   localparam int DW = 32;
   localparam int RW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [4:0]    mode = '0;
   logic          cls = 1'b0;
   logic [1:0]    hs_kind = '0;
   logic [DW-1:0] base = '0, off_reg = '0, st_src = '0, rdata = '0;
   logic [3:0]    imm_hi = '0, imm_lo = '0;
   logic [RW-1:0] rd_idx = '0, rn_idx = '0;

   logic          out_valid, wb_en, is_load, hazard;
   logic [DW-1:0] ea, wb_val, ld_data, st_data;
   logic [1:0]    size;

   int ntests = 0;
   int nfail  = 0;
   bit done   = 0;

   // expected state of the reference model
   logic          x_valid = 0, x_wben = 0, x_load = 0, x_haz = 0;
   logic [DW-1:0] x_ea = 0, x_wbv = 0, x_ld = 0, x_st = 0;
   logic [1:0]    x_size = 0;
   logic [4:0]    x_mode = 0;
   logic          x_cls = 0;

   always #2 clk = ~clk;

   lsagu_top #(.DW(DW), .RW(RW), .ADDER_STYLE(1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .cls(cls),
      .hs_kind(hs_kind), .base(base), .off_reg(off_reg), .imm_hi(imm_hi),
      .imm_lo(imm_lo), .rd_idx(rd_idx), .rn_idx(rn_idx), .st_src(st_src),
      .rdata(rdata), .out_valid(out_valid), .ea(ea), .wb_en(wb_en),
      .wb_val(wb_val), .is_load(is_load), .size(size), .ld_data(ld_data),
      .st_data(st_data), .hazard(hazard)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      ntests++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare_all();
      string at;
      at = !x_mode[4] ? "R3" : (x_mode[1] ? "R5" : "R4");
      chk("R1", "out_valid", 64'(out_valid), 64'(x_valid));
      chk(at, "ea", 64'(ea), 64'(x_ea));
      chk(x_haz ? "R10" : at, "wb_en", 64'(wb_en), 64'(x_wben));
      chk(at, "wb_val", 64'(wb_val), 64'(x_wbv));
      chk("R9", "is_load", 64'(is_load), 64'(x_load));
      chk(x_cls ? "R8" : "R7", "size", 64'(size), 64'(x_size));
      chk(x_cls ? "R8" : "R7", "ld_data", 64'(ld_data), 64'(x_ld));
      chk(x_cls ? "R8" : "R7", "st_data", 64'(st_data), 64'(x_st));
      chk("R10", "hazard", 64'(hazard), 64'(x_haz));
      if (x_valid && !x_mode[3]) chk("R2", "sub wb_val", 64'(wb_val), 64'(x_wbv));
      if (x_valid && x_cls && x_mode[2]) chk("R6", "imm ea/wb", 64'(wb_val), 64'(x_wbv));
   endtask

   // one clock: compare previous results, drive new inputs, update model
   task automatic step(input logic v, input logic [4:0] md, input logic c,
                       input logic [1:0] k, input logic [DW-1:0] b,
                       input logic [DW-1:0] o, input logic [7:0] im,
                       input logic [RW-1:0] rd, input logic [RW-1:0] rn,
                       input logic [DW-1:0] sd, input logic [DW-1:0] rv);
      logic [DW-1:0] off, s;
      logic wraw, hz;
      @(negedge clk);
      compare_all();
      req_valid = v; mode = md; cls = c; hs_kind = k; base = b; off_reg = o;
      imm_hi = im[7:4]; imm_lo = im[3:0]; rd_idx = rd; rn_idx = rn;
      st_src = sd; rdata = rv;
      x_valid = v;
      if (v) begin
         off  = (c && md[2]) ? {24'd0, im} : o;
         s    = md[3] ? b + off : b - off;
         wraw = !md[4] || md[1];
         hz   = md[0] && wraw && (rd == rn);
         x_ea = md[4] ? s : b;
         x_wbv = s;
         x_wben = wraw && !hz;
         x_haz = hz;
         x_load = md[0];
         x_mode = md; x_cls = c;
         if (!c) begin
            x_size = md[2] ? 2'b00 : 2'b10;
            x_ld   = md[2] ? {24'd0, rv[7:0]} : rv;
            x_st   = md[2] ? {24'd0, sd[7:0]} : sd;
         end else begin
            x_st   = {16'd0, sd[15:0]};
            x_size = (md[0] && k == 2'b10) ? 2'b00 : 2'b01;
            if (k == 2'b10)      x_ld = {{24{rv[7]}}, rv[7:0]};
            else if (k == 2'b11) x_ld = {{16{rv[15]}}, rv[15:0]};
            else                 x_ld = {16'd0, rv[15:0]};
         end
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         ntests++; nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", "out_valid", 64'(out_valid), 0);
      chk("R11", "wb_en", 64'(wb_en), 0);
      chk("R11", "hazard", 64'(hazard), 0);
      chk("R11", "ea", 64'(ea), 0);
      chk("R11", "ld_data", 64'(ld_data), 0);
      rst_n = 1'b1;

      // every mode, both classes, both kinds of offset, distinct registers
      for (int c = 0; c < 2; c++)
         for (int md = 0; md < 32; md++)
            step(1, 5'(md), c[0], 2'(md), 32'h1000_0010, 32'h0000_0120, 8'h3C,
                 4'd2, 4'd5, 32'hA5C3_F18E, 32'h1234_8396 + 32'(md));

      // R2: wrap below zero and above top
      step(1, 5'b00010, 0, 0, 32'h0000_0004, 32'h8, 8'h0, 1, 2, 0, 0);
      step(1, 5'b10010, 1, 0, 32'h0000_0001, 0, 8'hFF, 1, 2, 0, 0);
      step(1, 5'b11010, 0, 0, 32'hFFFF_FFF0, 32'h20, 8'h0, 1, 2, 0, 0);
      step(1, 5'b11110, 1, 1, 32'hFFFF_FFFF, 0, 8'h01, 1, 2, 0, 32'h0000_7F80);

      // R10: destination equals base for loads and stores
      for (int md = 0; md < 32; md++)
         step(1, 5'(md), md[2], 2'b11, 32'h40, 32'h4, 8'h10, 4'd7, 4'd7,
              32'hFFFF_FFFF, 32'hFFFF_8080);

      // R1: idle cycles with moving inputs leave results unchanged
      for (int i = 0; i < 6; i++)
         step(0, 5'(i * 7), i[0], 2'(i), 32'(i * 99), 32'(i * 13), 8'(i), 4'(i), 4'(i), 32'(i), 32'(i));

      // random traffic
      for (int i = 0; i < 3000; i++)
         step(1'($urandom_range(0, 3) != 0), 5'($urandom), 1'($urandom), 2'($urandom),
              $urandom, $urandom, 8'($urandom), 4'($urandom), 4'($urandom),
              $urandom, $urandom);

      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule